// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an APB slave that owns an eight-pin bidirectional GPIO port. It holds three registers: pin data, pin direction and alternate-function select. It drives the pad output and output-enable lines, and it samples the pad inputs through a two-stage synchronizer. The data register is visible at every word offset of the lowest 1 KB of the block's space. In that window, address bits [9:2] do not pick a register. They act as a per-bit stencil: bit i of the stencil is PADDR[2+i]. A write changes only the data bits under set stencil bits. A read shows only those bits and returns zeros everywhere else. Firmware can therefore set some pins and clear others in one bus write, with no read-modify-write window.

The interrupt-register offsets, 0x404 to 0x41C, are decoded here but not stored here. The access is forwarded on a side port to a separate detection block, and the read returns that block's data.

A small state machine tracks the bus phase with three states: IDLE, SETUP and ACCESS. Its transitions are:
- IDLE to SETUP when PSEL rises with PENABLE low.
- SETUP to ACCESS when PENABLE rises with PSEL held.
- SETUP stays in SETUP while PSEL is high and PENABLE is low.
- SETUP to IDLE when PSEL drops.
- ACCESS to SETUP on a back-to-back transfer.
- ACCESS to IDLE otherwise.

A transfer takes effect only in an access cycle that directly follows a setup cycle.

Top module: `gpio_mask_port`

## Requirements
- R1: After the active-low reset, the data, direction and alternate-select registers read 0x00, and pad_out and pad_oe are all zero.
- R2: Any access with PADDR[11:10] = 00 targets the data register, and the stencil bit for data bit i is PADDR[2+i].
- R3: A data-window write loads PWDATA[i] into bit i only where the stencil bit is 1. Other bits hold their value. One write may set some selected pins and clear others.
- R4: A data-window read returns bit i in position i where the stencil bit is 1, and 0 elsewhere. A stencil of 0x00 reads 0.
- R5: The direction register at offset 0x400 makes pin i an output when bit i is 1. For output pins, the data read returns the stored value.
- R6: For pins whose direction bit is 0, the data read returns the pad level after a two-flop synchronizer. A pad change is not visible after one rising edge and is visible after two.
- R7: The alternate-select register is at offset 0x420. Where bit i is 0, pad_out[i] = data[i] and pad_oe[i] = direction[i]. Where bit i is 1, both come from alt_out[i] and alt_oe[i].
- R8: For offsets 0x404 to 0x41C, irq_sel is high in the access cycle, irq_wr follows PWRITE, irq_word = PADDR[4:2] and irq_wdata = PWDATA[7:0]. The read returns irq_rdata, and no local register changes.
- R9: Unmapped offsets read 0, and writes to them change nothing. PREADY is always 1 and PSLVERR is always 0.
- R10: An access cycle (PSEL and PENABLE high) that is not preceded by a setup cycle commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase flag |
| pwrite | input | 1 | 1 = write |
| paddr | input | 12 | Byte address within the block |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero when no read is active |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| pad_in | input | 8 | Asynchronous pad levels |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad output enable |
| alt_out | input | 8 | Peripheral-side drive value |
| alt_oe | input | 8 | Peripheral-side output enable |
| irq_sel | output | 1 | Access to the interrupt offsets this cycle |
| irq_wr | output | 1 | That access is a write |
| irq_word | output | 3 | Word index PADDR[4:2] of the interrupt register |
| irq_wdata | output | 8 | Forwarded write data |
| irq_rdata | input | 8 | Read data from the detection block |

## Verification
The properties assume that the bus keeps PADDR, PWRITE and PWDATA steady from setup through access. They also assume that a commit is only ever the cycle after a PSEL-high, PENABLE-low cycle. The synchronizer-latency property assumes nothing about pad timing except that it is sampled on the clock. The bench drives every bus signal on the falling edge and changes nothing within a transfer. It alters pad_in only on a falling edge, and at least two edges before the level it checks, except for the deliberate one-edge probe. The one off-protocol stimulus is a lone access cycle with no setup. It is used only to show that R10 discards it.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;

    // Bus phase seen on the previous clock edge.
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACCESS = 2'd2
    } apb_phase_e;

    // Control-page offsets. Interrupt registers occupy the words between them.
    localparam logic [11:0] OFF_CTRL_BASE = 12'h400;   // direction word
    localparam logic [11:0] OFF_ALTSEL    = 12'h420;   // alternate-select word

endpackage

// File: rtl/gpio_apb_fsm.sv
`timescale 1ns/1ps
module gpio_apb_fsm
    import gpio_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    output logic commit
);

    apb_phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = PH_IDLE;
        unique case (state_q)
            PH_IDLE: begin
                if (psel && !penable) state_d = PH_SETUP;
                else                  state_d = PH_IDLE;
            end
            PH_SETUP: begin
                if (psel && penable)  state_d = PH_ACCESS;
                else if (psel)        state_d = PH_SETUP;
                else                  state_d = PH_IDLE;
            end
            PH_ACCESS: begin
                if (psel && !penable) state_d = PH_SETUP;
                else                  state_d = PH_IDLE;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Output process: a transfer takes effect only in an access cycle
    // that follows a setup cycle.
    always_comb begin
        commit = (state_q == PH_SETUP) && psel && penable;
    end

    // R10: a commit always has a setup cycle right before it.
    a_r10_commit_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(psel && !penable));

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pin_sync
);

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        logic meta_q, stable_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= pad_in[gi];
                stable_q <= meta_q;
            end
        end
        assign pin_sync[gi] = stable_q;
    end

    // Warm-up counter so the latency check never looks past reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               warm_q <= 2'd0;
        else if (warm_q != 2'd2)  warm_q <= warm_q + 2'd1;
    end

    // R6: synchronized level equals the pad level two edges earlier.
    a_r6_two_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (pin_sync == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [NPINS-1:0]  pin_sync,
    input  logic [NPINS-1:0]  irq_rdata,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  afsel_q,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_sel,
    output logic              irq_wr,
    output logic [2:0]        irq_word,
    output logic [NPINS-1:0]  irq_wdata
);

    localparam int WIN_LSB = 2 + NPINS;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(OFF_CTRL_BASE);
    localparam logic [ADDR_W-1:0] ALT_ADDR  = ADDR_W'(OFF_ALTSEL);

    logic             in_win, hit_dir, hit_alt, hit_irq;
    logic [NPINS-1:0] mask, win_view, wdat;

    assign in_win  = (paddr[ADDR_W-1:WIN_LSB] == '0);
    assign mask    = paddr[WIN_LSB-1:2];
    assign hit_dir = (paddr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2]);
    assign hit_alt = (paddr[ADDR_W-1:2] == ALT_ADDR[ADDR_W-1:2]);
    assign hit_irq = (paddr[ADDR_W-1:5] == CTRL_ADDR[ADDR_W-1:5]) && (paddr[4:2] != 3'd0);
    assign wdat    = pwdata[NPINS-1:0];

    logic unused_bus_bits;
    assign unused_bus_bits = ^{paddr[1:0], pwdata[DATA_W-1:NPINS]};

    // Per-pin read view: output pins show the stored value, inputs the pad.
    for (genvar gi = 0; gi < NPINS; gi++) begin : g_view
        assign win_view[gi] = dir_q[gi] ? data_q[gi] : pin_sync[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            dir_q   <= '0;
            afsel_q <= '0;
        end else if (commit && pwrite) begin
            if (in_win)  data_q  <= (data_q & ~mask) | (wdat & mask);
            if (hit_dir) dir_q   <= wdat;
            if (hit_alt) afsel_q <= wdat;
        end
    end

    always_comb begin
        rd_data = '0;
        if (in_win)       rd_data[NPINS-1:0] = win_view & mask;
        else if (hit_dir) rd_data[NPINS-1:0] = dir_q;
        else if (hit_alt) rd_data[NPINS-1:0] = afsel_q;
        else if (hit_irq) rd_data[NPINS-1:0] = irq_rdata;
    end

    assign irq_sel   = commit && hit_irq;
    assign irq_wr    = irq_sel && pwrite;
    assign irq_word  = paddr[4:2];
    assign irq_wdata = wdat;

    // R3: bits outside the stencil hold; bits inside it take the write data.
    for (genvar gi = 0; gi < NPINS; gi++) begin : g_chk
        a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && pwrite && in_win && !paddr[2+gi]) |=> $stable(data_q[gi]));
        a_r3_masked_load: assert property (@(posedge clk) disable iff (!rst_n)
            (commit && pwrite && in_win && paddr[2+gi]) |=> (data_q[gi] == $past(pwdata[gi])));
    end

    // R9/R10: no committed write, no register change.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && pwrite) |=> ($stable(data_q) && $stable(dir_q) && $stable(afsel_q)));

    // R8: forwarded accesses leave local storage untouched.
    a_r8_irq_leaves_local: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sel |=> ($stable(data_q) && $stable(dir_q) && $stable(afsel_q)));

endmodule

// File: rtl/gpio_pad_mux.sv
`timescale 1ns/1ps
module gpio_pad_mux #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] data_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] afsel_q,
    input  logic [NPINS-1:0] alt_out,
    input  logic [NPINS-1:0] alt_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pad
        assign pad_out[gi] = afsel_q[gi] ? alt_out[gi] : data_q[gi];
        assign pad_oe[gi]  = afsel_q[gi] ? alt_oe[gi]  : dir_q[gi];
    end

endmodule

// File: rtl/gpio_mask_port.sv
`timescale 1ns/1ps
module gpio_mask_port #(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic              irq_sel,
    output logic              irq_wr,
    output logic [2:0]        irq_word,
    output logic [NPINS-1:0]  irq_wdata,
    input  logic [NPINS-1:0]  irq_rdata
);

    logic              commit;
    logic [NPINS-1:0]  pin_sync, data_q, dir_q, afsel_q;
    logic [DATA_W-1:0] rd_data;

    gpio_apb_fsm u_fsm (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .commit  (commit)
    );

    gpio_in_sync #(.NPINS(NPINS)) u_sync (
        .clk      (pclk),
        .rst_n    (presetn),
        .pad_in   (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .commit    (commit),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .pin_sync  (pin_sync),
        .irq_rdata (irq_rdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .afsel_q   (afsel_q),
        .rd_data   (rd_data),
        .irq_sel   (irq_sel),
        .irq_wr    (irq_wr),
        .irq_word  (irq_word),
        .irq_wdata (irq_wdata)
    );

    gpio_pad_mux #(.NPINS(NPINS)) u_pad (
        .data_q  (data_q),
        .dir_q   (dir_q),
        .afsel_q (afsel_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign prdata  = (psel && !pwrite) ? rd_data : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: tb/gpio_mask_port_test.sv
`timescale 1ns/1ps
module gpio_mask_port_test;

    logic        clk = 1'b0;
    logic        presetn;
    logic        psel, penable, pwrite;
    logic [11:0] paddr;
    logic [31:0] pwdata, prdata;
    logic        pready, pslverr;
    logic [7:0]  pad_in, pad_out, pad_oe, alt_out, alt_oe;
    logic        irq_sel, irq_wr;
    logic [2:0]  irq_word;
    logic [7:0]  irq_wdata, irq_rdata;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [31:0] cap_prdata;
    logic        cap_sel, cap_wr, cap_ready, cap_err;
    logic [2:0]  cap_word;
    logic [7:0]  cap_wdata;

    logic [7:0] exp_data, exp_dir, prev_pad;

    always #2.5 clk = ~clk;

    gpio_mask_port uut (
        .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe), .irq_sel(irq_sel),
        .irq_wr(irq_wr), .irq_word(irq_word), .irq_wdata(irq_wdata),
        .irq_rdata(irq_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic capture();
        cap_prdata = prdata;
        cap_sel    = irq_sel;
        cap_wr     = irq_wr;
        cap_word   = irq_word;
        cap_wdata  = irq_wdata;
        cap_ready  = pready;
        cap_err    = pslverr;
    endtask

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1; #1; capture();
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [11:0] a);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1; #1; capture();
        @(negedge clk); psel = 0; penable = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            miscompares++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        pad_in = 8'h00; alt_out = 8'h00; alt_oe = 8'h00; irq_rdata = 8'h00;
        prev_pad = 8'h00;
        repeat (3) @(negedge clk);
        presetn = 1;

        // R1 reset state
        chk("R1 pad_out", {24'h0, pad_out}, 32'h0);
        chk("R1 pad_oe", {24'h0, pad_oe}, 32'h0);
        apb_read(12'h3FC); chk("R1 data", cap_prdata, 32'h0);
        chk("R9 pready", {31'h0, cap_ready}, 32'h1);
        chk("R9 pslverr", {31'h0, cap_err}, 32'h0);
        apb_read(12'h400); chk("R1 dir", cap_prdata, 32'h0);
        apb_read(12'h420); chk("R1 afsel", cap_prdata, 32'h0);

        // R5 direction register
        apb_write(12'h400, 32'hFFFF_FFFF); exp_dir = 8'hFF;
        apb_read(12'h400); chk("R5 dir readback", cap_prdata, 32'hFF);
        chk("R5 pad_oe", {24'h0, pad_oe}, 32'hFF);

        // R2/R3/R4 exhaustive stencil sweep
        exp_data = 8'h00;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] mk, v, m2;
            mk = 8'(m);
            v  = 8'((m * 37 + 11) & 8'hFF);
            apb_write({2'b00, mk, 2'b00}, {24'hA5C3E1, v});
            chk("R2 no irq forward in window", {31'h0, cap_sel}, 32'h0);
            exp_data = (exp_data & ~mk) | (v & mk);
            apb_read(12'h3FC); chk("R3 masked write", cap_prdata, {24'h0, exp_data});
            m2 = mk ^ 8'h5A;
            apb_read({2'b00, m2, 2'b00}); chk("R4 masked read", cap_prdata, {24'h0, exp_data & m2});
            chk("R7 pad_out gpio", {24'h0, pad_out}, {24'h0, exp_data});
        end

        // R3 set and clear in one write
        apb_write(12'h3FC, 32'hAA); exp_data = 8'hAA;
        apb_write(12'h3C0, 32'h50); exp_data = 8'h5A;
        apb_read(12'h3FC); chk("R3 set+clear", cap_prdata, 32'h5A);
        apb_read(12'h000); chk("R4 zero stencil", cap_prdata, 32'h0);

        // R6 input pins through the synchronizer
        apb_write(12'h400, 32'h0F); exp_dir = 8'h0F;
        foreach (prev_pad[k]) begin end
        for (int k = 0; k < 5; k++) begin
            logic [7:0] p;
            case (k)
                0: p = 8'hFF; 1: p = 8'hA5; 2: p = 8'h3C; 3: p = 8'h81; default: p = 8'h00;
            endcase
            @(negedge clk); pad_in = p; psel = 1; penable = 0; pwrite = 0; paddr = 12'h3FC;
            @(negedge clk); penable = 1; #1;
            chk("R6 one edge old", prdata, {24'h0, (exp_data & exp_dir) | (prev_pad & ~exp_dir)});
            @(negedge clk); psel = 0; penable = 0;
            apb_read(12'h3FC);
            chk("R6 input level", cap_prdata, {24'h0, (exp_data & exp_dir) | (p & ~exp_dir)});
            apb_read(12'h0F0);
            chk("R6 masked input", cap_prdata, {24'h0, ((exp_data & exp_dir) | (p & ~exp_dir)) & 8'h3C});
            prev_pad = p;
        end

        // R7 alternate-function select
        alt_out = 8'h9A; alt_oe = 8'h3C;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] af;
            case (k) 0: af = 8'h00; 1: af = 8'hC3; 2: af = 8'hFF; default: af = 8'h18; endcase
            apb_write(12'h420, {24'h0, af});
            apb_read(12'h420); chk("R7 afsel readback", cap_prdata, {24'h0, af});
            chk("R7 pad_out", {24'h0, pad_out}, {24'h0, (alt_out & af) | (exp_data & ~af)});
            chk("R7 pad_oe", {24'h0, pad_oe}, {24'h0, (alt_oe & af) | (exp_dir & ~af)});
        end
        apb_write(12'h420, 32'h0);

        // R8 interrupt offsets forwarded
        for (int w = 1; w < 8; w++) begin
            logic [11:0] a;
            a = 12'h400 + 12'(4 * w);
            irq_rdata = 8'(w * 29);
            apb_write(a, 32'h1234_5600 | 32'(w * 17));
            chk("R8 irq_sel wr", {31'h0, cap_sel}, 32'h1);
            chk("R8 irq_wr", {31'h0, cap_wr}, 32'h1);
            chk("R8 irq_word", {29'h0, cap_word}, 32'(w));
            chk("R8 irq_wdata", {24'h0, cap_wdata}, 32'(w * 17));
            apb_read(a);
            chk("R8 irq read", cap_prdata, 32'(w * 29));
            chk("R8 irq_sel rd", {31'h0, cap_sel}, 32'h1);
            chk("R8 irq_wr rd", {31'h0, cap_wr}, 32'h0);
        end
        apb_read(12'h400); chk("R8 dir kept", cap_prdata, {24'h0, exp_dir});
        chk("R8 no forward on dir", {31'h0, cap_sel}, 32'h0);
        apb_read(12'h420); chk("R8 afsel kept", cap_prdata, 32'h0);

        // R9 unmapped offsets
        for (int k = 0; k < 6; k++) begin
            logic [11:0] a;
            case (k)
                0: a = 12'h424; 1: a = 12'h43C; 2: a = 12'h800;
                3: a = 12'hC00; 4: a = 12'hFFC; default: a = 12'h500;
            endcase
            apb_write(a, 32'hFFFF_FFFF);
            chk("R9 pslverr", {31'h0, cap_err}, 32'h0);
            apb_read(a); chk("R9 unmapped read", cap_prdata, 32'h0);
            chk("R9 pready", {31'h0, cap_ready}, 32'h1);
        end
        apb_read(12'h400); chk("R9 dir kept", cap_prdata, {24'h0, exp_dir});
        apb_read(12'h420); chk("R9 afsel kept", cap_prdata, 32'h0);
        apb_write(12'h400, 32'hFF); exp_dir = 8'hFF;
        apb_read(12'h3FC); chk("R9 data kept", cap_prdata, {24'h0, exp_data});

        // R10 access without setup is ignored
        @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = 12'h400; pwdata = 32'h0;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        apb_read(12'h400); chk("R10 dir untouched", cap_prdata, 32'hFF);
        @(negedge clk); psel = 1; penable = 1; pwrite = 1; paddr = 12'h3FC; pwdata = 32'h0;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
        apb_read(12'h3FC); chk("R10 data untouched", cap_prdata, {24'h0, exp_data});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule